// File: doc/BRIEF.md
# Two-Wire-Per-Bit Toggle Link

This block holds both ends of a word link whose ends share no timing. Each bit of the word has its own pair of wires. A transition on the pair's low wire carries a 0, and a transition on its high wire carries a 1. The resting level of a wire means nothing: only a change from the last level seen counts. Because every bit announces its own arrival, the receiver needs no separate strobe. It knows the word is whole once each pair has shown exactly one change.

The sending end takes a parallel word through a ready/valid handshake. It flips one wire of each pair and then holds its wires still until the receiving end's acknowledge wire changes level. The receiving end records which wire changed for every bit, and bits may land in different cycles. When the last bit lands, it issues the rebuilt word with a one-cycle valid pulse and flips its acknowledge wire.

If a pair shows an impossible pattern, the receiver sets a sticky error flag. Two cases count as impossible: both wires of a pair change in the same cycle, or a bit that has already arrived changes again before the word completes. Both ends are modelled as sampled logic in one fast clock domain. The link wires leave and enter through ports, so that the two ends can be looped back or driven apart.

Top module: `dr_link_top`

## Requirements
- R1: During and after reset, every sending-side link wire and the acknowledge output are 0, `snd_ready` is 1, and `rcv_valid` and `rcv_err` are 0.
- R2: On the clock edge where `snd_valid` and `snd_ready` are both high, each bit i flips exactly one wire, and the new levels are visible after that edge: `tx_zero[i]` flips when data bit i is 0, and `tx_one[i]` flips when it is 1.
- R3: From an accepted word until the acknowledge toggle is seen, `snd_ready` is 0. Any `snd_valid` or `snd_data` in that time is ignored, and the sending wires stay unchanged.
- R4: A receiving bit i counts as arrived when exactly one of `rx_zero[i]`/`rx_one[i]` differs from its last sampled level. Its value is 1 if `rx_one[i]` changed and 0 if `rx_zero[i]` changed.
- R5: The word completes when every bit has arrived, even if the bits arrive in different cycles. One cycle after the edge that samples the last arrival, `rcv_valid` is high for exactly one cycle, `rcv_data` holds the word, and `rx_ack` has flipped.
- R6: Wire levels carry no meaning. Repeated identical words, and words sent from any mix of starting levels, are received correctly.
- R7: If both wires of a pair change in the same sampled cycle, `rcv_err` rises on the next edge and stays high until reset.
- R8: If an already-arrived bit changes again before its word completes, `rcv_err` rises on the next edge.
- R9: The sending end samples `tx_ack` on each edge. After the edge where it sees a changed level while a word is pending, `snd_ready` is 1 again.
- R10: An acknowledge change while no word is pending has no effect: `snd_ready` stays 1 and the sending wires keep their levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for both ends |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| snd_valid | input | 1 | Word offered to the sending end |
| snd_data | input | W | Word to send |
| snd_ready | output | 1 | Sending end can take a word |
| tx_zero | output | W | Sending wires that signal a 0 by toggling |
| tx_one | output | W | Sending wires that signal a 1 by toggling |
| tx_ack | input | 1 | Acknowledge wire coming back from the far receiver |
| rx_zero | input | W | Receiving wires that signal a 0 by toggling |
| rx_one | input | W | Receiving wires that signal a 1 by toggling |
| rx_ack | output | 1 | Acknowledge wire to the far sender, toggles per word |
| rcv_valid | output | 1 | One-cycle pulse with a complete word |
| rcv_data | output | W | Rebuilt word, held until the next one |
| rcv_err | output | 1 | Sticky protocol error |

## Verification
Suppose a lane's stored wire level or arrival flag is wrong. The port effect depends on the case. A missed arrival keeps `rcv_valid` low past the cycle after the last toggle. A wrong level makes an arrival register early, or raises `rcv_err`, within one edge of the next toggle on that pair. A wrong sampled value shows in `rcv_data` on the valid pulse. On the sending side, a wrong busy state shows at once as `snd_ready` rising before the acknowledge or staying low after it. Wrong pending wire levels show as a pair where both or neither wire flips, one edge after acceptance.

// File: rtl/dr_link_pkg.sv
package dr_link_pkg;
  // one wire pair as sampled at the receiver
  typedef struct packed {
    logic zero;
    logic one;
  } rail_pair_t;
endpackage

// File: rtl/dr_rst_sync.sv
module dr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/dr_tx.sv
module dr_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         snd_valid_i,
  input  logic [W-1:0] snd_data_i,
  output logic         snd_ready_o,
  output logic [W-1:0] zero_o,
  output logic [W-1:0] one_o,
  input  logic         ack_i
);
  logic [W-1:0] zero_q, zero_d, one_q, one_d;
  logic         busy_q, busy_d;
  logic         ack_seen_q;
  logic         accept, ack_tgl;

  assign accept  = snd_valid_i && !busy_q;
  assign ack_tgl = ack_i ^ ack_seen_q;

  always_comb begin
    zero_d = zero_q;
    one_d  = one_q;
    busy_d = busy_q;
    if (accept) begin
      zero_d = zero_q ^ ~snd_data_i;
      one_d  = one_q ^ snd_data_i;
      busy_d = 1'b1;
    end else if (busy_q && ack_tgl) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_q <= '0;
      one_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (accept) begin
        zero_q <= zero_d;
        one_q  <= one_d;
      end
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ack_seen_q <= 1'b0;
    else if (ack_tgl) ack_seen_q <= ack_i;
  end

  assign snd_ready_o = !busy_q;
  assign zero_o      = zero_q;
  assign one_o       = one_q;

  // R2: each accepted word flips exactly one wire per pair
  p_one_wire_per_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (((zero_q ^ $past(zero_q)) ^ (one_q ^ $past(one_q))) == {W{1'b1}}));

  // R3: wires frozen while waiting for acknowledge
  p_hold_while_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ack_tgl) |=> (busy_q && $stable(zero_q) && $stable(one_q)));

  // R10: idle end ignores acknowledge changes
  p_idle_ack_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !snd_valid_i) |=> (!busy_q && $stable(zero_q) && $stable(one_q)));
endmodule

// File: rtl/dr_rx_lane.sv
module dr_rx_lane
  import dr_link_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic zero_i,
  input  logic one_i,
  input  logic clr_i,
  output logic got_o,
  output logic val_o,
  output logic bad_o
);
  rail_pair_t lvl_q, lvl_in;
  logic       got_q, got_d, val_q, val_d;
  logic       chg_zero, chg_one, chg_any, fresh;

  assign lvl_in   = '{zero: zero_i, one: one_i};
  assign chg_zero = lvl_in.zero ^ lvl_q.zero;
  assign chg_one  = lvl_in.one ^ lvl_q.one;
  assign chg_any  = chg_zero | chg_one;
  assign fresh    = !got_q && (chg_zero ^ chg_one);

  always_comb begin
    got_d = clr_i ? 1'b0 : got_q;
    val_d = val_q;
    if (fresh) begin
      got_d = 1'b1;
      val_d = chg_one;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      got_q <= 1'b0;
      val_q <= 1'b0;
    end else begin
      if (chg_any) lvl_q <= lvl_in;
      if (fresh || clr_i) got_q <= got_d;
      if (fresh) val_q <= val_d;
    end
  end

  assign got_o = got_q;
  assign val_o = val_q;
  assign bad_o = (chg_zero & chg_one) | (got_q & chg_any);

  // R4: a single-wire change on a waiting lane marks it arrived
  p_arrival_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!got_q && (chg_zero != chg_one)) |=> (got_q && (val_q == $past(chg_one))));
endmodule

// File: rtl/dr_rx.sv
module dr_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] zero_i,
  input  logic [W-1:0] one_i,
  output logic         ack_o,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         err_o
);
  logic [W-1:0] got, val, bad;
  logic         all_got;
  logic         ack_q, valid_q, err_q;
  logic [W-1:0] data_q;

  for (genvar i = 0; i < W; i++) begin : g_lane
    dr_rx_lane u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .zero_i (zero_i[i]),
      .one_i  (one_i[i]),
      .clr_i  (all_got),
      .got_o  (got[i]),
      .val_o  (val[i]),
      .bad_o  (bad[i])
    );
  end

  assign all_got = &got;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= all_got;
      if (all_got) begin
        data_q <= val;
        ack_q  <= !ack_q;
      end
      if (|bad) err_q <= 1'b1;
    end
  end

  assign ack_o   = ack_q;
  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign err_o   = err_q;

  // R5: valid is a single-cycle pulse
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R5: acknowledge flips exactly with each delivered word
  p_ack_with_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q != $past(ack_q)) == valid_q);

  // R5: a word is only delivered after all lanes had arrived
  p_complete_before_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(all_got));

  // R7: error flag holds until reset
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/dr_link_top.sv
module dr_link_top #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         snd_valid,
  input  logic [W-1:0] snd_data,
  output logic         snd_ready,
  output logic [W-1:0] tx_zero,
  output logic [W-1:0] tx_one,
  input  logic         tx_ack,
  input  logic [W-1:0] rx_zero,
  input  logic [W-1:0] rx_one,
  output logic         rx_ack,
  output logic         rcv_valid,
  output logic [W-1:0] rcv_data,
  output logic         rcv_err
);
  logic rst_n_int;

  dr_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  dr_tx #(.W(W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .snd_valid_i (snd_valid),
    .snd_data_i  (snd_data),
    .snd_ready_o (snd_ready),
    .zero_o      (tx_zero),
    .one_o       (tx_one),
    .ack_i       (tx_ack)
  );

  dr_rx #(.W(W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .zero_i  (rx_zero),
    .one_i   (rx_one),
    .ack_o   (rx_ack),
    .valid_o (rcv_valid),
    .data_o  (rcv_data),
    .err_o   (rcv_err)
  );
endmodule

// File: tb/dr_link_top_tb.sv
module dr_link_top_tb;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         snd_valid;
  logic [W-1:0] snd_data;
  logic         snd_ready;
  logic [W-1:0] tx_zero, tx_one, rx_zero, rx_one;
  logic         rx_ack, rcv_valid, rcv_err;
  logic [W-1:0] rcv_data;

  logic         inject;
  logic [W-1:0] iz, io;
  logic [W-1:0] mz, mo;
  logic         mack;
  int           n_chk = 0, n_bad = 0;
  bit           done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rx_zero = inject ? iz : tx_zero;
  assign rx_one  = inject ? io : tx_one;

  dr_link_top #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .snd_valid(snd_valid), .snd_data(snd_data),
    .snd_ready(snd_ready), .tx_zero(tx_zero), .tx_one(tx_one), .tx_ack(rx_ack),
    .rx_zero(rx_zero), .rx_one(rx_one), .rx_ack(rx_ack),
    .rcv_valid(rcv_valid), .rcv_data(rcv_data), .rcv_err(rcv_err)
  );

  function automatic logic [W-1:0] exp_zero(input logic [W-1:0] lv, input logic [W-1:0] d);
    return lv ^ ~d;
  endfunction
  function automatic logic [W-1:0] exp_one(input logic [W-1:0] lv, input logic [W-1:0] d);
    return lv ^ d;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    snd_valid = 1'b0;
    snd_data = '0;
    iz = '0; io = '0;
    mz = '0; mo = '0; mack = 1'b0;
    repeat (3) @(negedge clk);
    check(tx_zero == '0 && tx_one == '0, "R1 wires", {tx_zero, tx_one}, 0);
    check(snd_ready && !rcv_valid && !rcv_err && !rx_ack, "R1 flags",
          {snd_ready, rcv_valid, rcv_err, rx_ack}, 4'b1000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(snd_ready && !rcv_err && tx_zero == '0, "R1 after release", {snd_ready, rcv_err}, 2'b10);
  endtask

  // loopback send; hammer keeps offering other data while busy
  task automatic send_word(input logic [W-1:0] d, input bit hammer);
    logic [W-1:0] ez, eo;
    ez = exp_zero(mz, d);
    eo = exp_one(mo, d);
    while (!snd_ready) @(negedge clk);
    snd_valid = 1'b1;
    snd_data  = d;
    @(negedge clk);                       // one edge after accept
    if (hammer) snd_data = ~d; else snd_valid = 1'b0;
    check(tx_zero == ez && tx_one == eo, "R2 wire flips", {tx_zero, tx_one}, {ez, eo});
    check(!snd_ready, "R3 ready low", snd_ready, 0);
    @(negedge clk);
    check(!rcv_valid, "R5 not early", rcv_valid, 0);
    check(tx_zero == ez && tx_one == eo, "R3 wires held", {tx_zero, tx_one}, {ez, eo});
    @(negedge clk);
    snd_valid = 1'b0;
    check(rcv_valid, "R5 valid", rcv_valid, 1);
    check(rcv_data == d, "R4 R6 data", rcv_data, d);
    check(rx_ack == !mack, "R5 ack flip", rx_ack, !mack);
    check(!snd_ready && tx_zero == ez, "R3 held until ack", snd_ready, 0);
    @(negedge clk);
    check(snd_ready, "R9 ready back", snd_ready, 1);
    check(!rcv_valid, "R5 one cycle", rcv_valid, 0);
    mz = ez; mo = eo; mack = !mack;
  endtask

  // injected word with per-bit skew; the last bit lands three cycles late
  task automatic inject_word(input logic [W-1:0] d);
    int dl [W];
    for (int i = 0; i < W; i++) dl[i] = $urandom % 4;
    dl[$urandom % W] = 3;
    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < W; i++)
        if (dl[i] == t) begin
          if (d[i]) io[i] = !io[i]; else iz[i] = !iz[i];
        end
      if (t > 0) check(!rcv_valid, "R5 waits for last bit", rcv_valid, 0);
      @(negedge clk);
    end
    check(!rcv_valid, "R5 not before last sample", rcv_valid, 0);
    @(negedge clk);
    check(rcv_valid && rcv_data == d, "R4 R5 skewed word", rcv_data, d);
    check(rx_ack == !mack, "R5 ack flip skewed", rx_ack, !mack);
    mack = !mack;
    @(negedge clk);
    check(snd_ready && tx_zero == mz && tx_one == mo, "R10 idle ack ignored",
          {tx_zero, tx_one}, {mz, mo});
  endtask

  initial begin
    void'($urandom(32'd1357));
    inject = 1'b0;
    do_reset();

    // directed: constant levels and repeats
    send_word('0, 1'b0);
    send_word('0, 1'b1);
    send_word('1, 1'b0);
    send_word('1, 1'b0);
    send_word(8'hA5, 1'b1);
    for (int n = 0; n < 60; n++) send_word(W'($urandom), n[0]);

    // switch to injected wires starting from present levels
    iz = tx_zero; io = tx_one;
    inject = 1'b1;
    @(negedge clk);
    for (int n = 0; n < 40; n++) inject_word(W'($urandom));
    inject_word('1);
    inject_word('1);

    // R7: both wires of a pair in one cycle
    check(!rcv_err, "R7 clean before", rcv_err, 0);
    iz[3] = !iz[3]; io[3] = !io[3];
    @(negedge clk);
    check(rcv_err, "R7 err raised", rcv_err, 1);
    repeat (3) @(negedge clk);
    check(rcv_err, "R7 err sticky", rcv_err, 1);

    inject = 1'b1;
    do_reset();
    check(!rcv_err, "R1 err cleared", rcv_err, 0);

    // R8: second change on an arrived bit
    iz[2] = !iz[2];
    @(negedge clk);
    check(!rcv_err, "R8 first toggle legal", rcv_err, 0);
    io[2] = !io[2];
    @(negedge clk);
    check(rcv_err, "R8 repeat toggle", rcv_err, 1);

    inject = 1'b0;
    do_reset();
    send_word(8'h3C, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule